// File: doc/BRIEF.md
# Outstanding-Transaction Ordering Monitor

This block is a passive, synthesizable observer for one request/response channel pair of an AXI-style port, either the read pair or the write pair. It watches handshakes without driving anything on the bus. Every accepted request is written into a bounded table of in-flight transactions. Each entry holds the request ID, a tag, the start and end addresses, and the position of that request in its own ID's issue stream. Each returning response is paired with its request through the response ID together with a tag that the responder echoes on a user sideband. Arrival position plays no part in the pairing.

Four faults are reported as sticky flags. An ordering fault is a response that completes a request ahead of an older request with the same ID. An unexpected-response fault is a response that pairs with nothing in the table. An overflow fault is a request accepted while the table is already full. An address hazard is a newly recorded request whose byte range intersects the range of an in-flight request with a different ID. A saturating counter totals the fault events. A synchronous clear input resets the flags and the counter without touching the table.

The parameter `IS_READ` selects the channel flavour. With `IS_READ` = 1, a response retires its request only on the beat that carries the last-beat marker. With `IS_READ` = 0, every response handshake retires a request.

Top module: `txn_order_monitor`

## Requirements
- R1: A request is recorded only on a cycle where `reqValid` and `reqReady` are both high. A later response carrying the same ID and tag retires that entry without raising any flag, and a second identical response then reports as unexpected.
- R2: In read mode (the default), a response beat with `rspLast` low retires nothing and raises nothing. Only a handshake with `rspLast` high retires an entry.
- R3: Responses with different IDs may return in any relative order without raising `orderErr`.
- R4: Each ID keeps an issue count and a retire count, both 4 bits wide by default and wrapping. A retiring entry whose issue number differs from its ID's retire count sets `orderErr` and adds one to `errCount`. Every response to that ID advances the retire count, so a swapped pair of same-ID responses counts two events.
- R5: A completing response whose ID and tag match no valid entry sets `unexpErr`, adds one to `errCount`, and leaves the table unchanged.
- R6: A request accepted while all `DEPTH` entries (8 by default) are valid sets `overflowErr` and is not recorded, so a response to it later reports as unexpected.
- R7: A recorded request sets `hazardErr` when its inclusive range [addr, addr + (len+1)·2^size − 1] intersects the range of a valid entry with a different ID. The check uses the table as it stood before that cycle. Ranges that overlap but share the same ID raise nothing, and ranges that only touch end to end raise nothing.
- R8: All four flags stay high until `clearErr` or reset. A cycle with `clearErr` high leaves every flag and `errCount` at zero, even if fault events occur in that same cycle.
- R9: `errCount` adds the number of fault events in each cycle and saturates at 2^CNTW − 1 (255 by default).
- R10: While `rst_n` is low and after it rises, all flags and `errCount` are zero and the table is empty.
- R11: Flags and `errCount` are registered. They reflect a handshake from the clock edge that samples it onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clearErr | input | 1 | Synchronous clear of flags and counter |
| reqValid | input | 1 | Request valid |
| reqReady | input | 1 | Request ready |
| reqId | input | IDW | Request ID |
| reqAddr | input | AW | Request start address |
| reqLen | input | LENW | Burst length minus one |
| reqSize | input | SIZEW | Log2 of bytes per beat |
| reqTag | input | TAGW | Request user tag |
| rspValid | input | 1 | Response valid |
| rspReady | input | 1 | Response ready |
| rspId | input | IDW | Response ID |
| rspTag | input | TAGW | Tag echoed with the response |
| rspLast | input | 1 | Last beat marker (read mode) |
| orderErr | output | 1 | Same-ID ordering fault, sticky |
| unexpErr | output | 1 | Unmatched response, sticky |
| overflowErr | output | 1 | Request while table full, sticky |
| hazardErr | output | 1 | Cross-ID address overlap, sticky |
| errCount | output | CNTW | Saturating fault event count |

## Verification
Every result of this block lands exactly one rising edge after the handshake that causes it. This holds for a retirement, a recorded request, any of the four flags, the counter step and a clear. No result has more latency than that. The bench therefore changes inputs on a falling edge and lets one rising edge pass. It compares all outputs on the following falling edge against a reference table. That reference table is updated from the same inputs, using the state it held before that edge. Directed sequences pin the exact cycle of each flag: a non-last beat, a swapped same-ID pair, adjacent and overlapping ranges, a full table plus one extra request, and counter saturation. A long seeded random phase then mixes retirements, bogus responses and clears.

// File: rtl/txn_order_pkg.sv
package txn_order_pkg;

  // Strobes from the control to the table.
  typedef struct packed {
    logic capture;
    logic retire;
  } tblStrobe_t;

  // Lookup results from the table to the control.
  typedef struct packed {
    logic full;
    logic rspHit;
    logic seqMismatch;
    logic overlap;
  } tblStatus_t;

endpackage

// File: rtl/txn_order_table.sv
module txn_order_table
  import txn_order_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDW   = 4,
  parameter int TAGW  = 4,
  parameter int AW    = 32,
  parameter int LENW  = 8,
  parameter int SIZEW = 3,
  parameter int SEQW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tblStrobe_t       strb,
  input  logic [IDW-1:0]   reqId,
  input  logic [AW-1:0]    reqAddr,
  input  logic [LENW-1:0]  reqLen,
  input  logic [SIZEW-1:0] reqSize,
  input  logic [TAGW-1:0]  reqTag,
  input  logic [IDW-1:0]   rspId,
  input  logic [TAGW-1:0]  rspTag,
  output tblStatus_t       stat
);
  localparam int IDN  = 1 << IDW;
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EAW  = AW + 1;   // one spare bit so the end address cannot wrap

  logic [DEPTH-1:0] entValid;
  logic [IDW-1:0]   entId    [DEPTH];
  logic [TAGW-1:0]  entTag   [DEPTH];
  logic [EAW-1:0]   entStart [DEPTH];
  logic [EAW-1:0]   entEnd   [DEPTH];
  logic [SEQW-1:0]  entSeq   [DEPTH];
  logic [SEQW-1:0]  issueCnt [IDN];
  logic [SEQW-1:0]  retireCnt[IDN];

  logic [EAW-1:0]   reqStartX, reqSpan, reqEndX;
  logic [DEPTH-1:0] hitVec, ovlVec;
  logic [IDXW-1:0]  hitIdx, freeIdx;

  assign reqStartX = {1'b0, reqAddr};
  assign reqSpan   = (EAW'(reqLen) + EAW'(1)) << reqSize;
  assign reqEndX   = reqStartX + reqSpan - EAW'(1);

  // One comparator set per entry: response match and range intersection.
  for (genvar g = 0; g < DEPTH; g++) begin : gEnt
    assign hitVec[g] = entValid[g] && (entId[g] == rspId) && (entTag[g] == rspTag);
    assign ovlVec[g] = entValid[g] && (entId[g] != reqId) &&
                       (entStart[g] <= reqEndX) && (reqStartX <= entEnd[g]);
  end

  // Lowest-index match and lowest-index free slot.
  always_comb begin
    hitIdx  = '0;
    freeIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hitVec[i])    hitIdx  = IDXW'(i);
      if (!entValid[i]) freeIdx = IDXW'(i);
    end
  end

  assign stat.full        = &entValid;
  assign stat.rspHit      = |hitVec;
  assign stat.overlap     = |ovlVec;
  assign stat.seqMismatch = entSeq[hitIdx] != retireCnt[rspId];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entValid <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        entId[i]    <= '0;
        entTag[i]   <= '0;
        entStart[i] <= '0;
        entEnd[i]   <= '0;
        entSeq[i]   <= '0;
      end
      for (int j = 0; j < IDN; j++) begin
        issueCnt[j]  <= '0;
        retireCnt[j] <= '0;
      end
    end else begin
      if (strb.retire) begin
        entValid[hitIdx]  <= 1'b0;
        retireCnt[rspId]  <= retireCnt[rspId] + SEQW'(1);
      end
      if (strb.capture) begin
        entValid[freeIdx] <= 1'b1;
        entId[freeIdx]    <= reqId;
        entTag[freeIdx]   <= reqTag;
        entStart[freeIdx] <= reqStartX;
        entEnd[freeIdx]   <= reqEndX;
        entSeq[freeIdx]   <= issueCnt[reqId];
        issueCnt[reqId]   <= issueCnt[reqId] + SEQW'(1);
      end
    end
  end

  // R6: the control never writes into a full table.
  a_r6_capture_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture |-> !stat.full);

  // R1: a capture leaves its slot valid on the next cycle.
  a_r1_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture |=> entValid[$past(freeIdx)]);

  // R1: a retirement frees the matched slot.
  a_r1_retire_clears: assert property (@(posedge clk) disable iff (!rst_n)
    strb.retire |=> !entValid[$past(hitIdx)]);

  // R5: only a matched response may retire.
  a_r5_retire_has_hit: assert property (@(posedge clk) disable iff (!rst_n)
    strb.retire |-> stat.rspHit);

endmodule

// File: rtl/txn_order_ctrl.sv
module txn_order_ctrl
  import txn_order_pkg::*;
#(
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clearErr,
  input  logic            reqFire,
  input  logic            rspFire,
  input  tblStatus_t      stat,
  output tblStrobe_t      strb,
  output logic            orderErr,
  output logic            unexpErr,
  output logic            overflowErr,
  output logic            hazardErr,
  output logic [CNTW-1:0] errCount
);
  localparam logic [CNTW-1:0] CNT_MAX = '1;

  logic evOrder, evUnexp, evOver, evHaz;
  logic [2:0]      evSum;
  logic [CNTW:0]   cntSum;
  logic [CNTW-1:0] cntNext;

  always_comb begin
    strb.capture = reqFire && !stat.full;
    strb.retire  = rspFire && stat.rspHit;
    evOrder      = strb.retire && stat.seqMismatch;
    evUnexp      = rspFire && !stat.rspHit;
    evOver       = reqFire && stat.full;
    evHaz        = strb.capture && stat.overlap;
    evSum        = {2'b0, evOrder} + {2'b0, evUnexp} + {2'b0, evOver} + {2'b0, evHaz};
    cntSum       = {1'b0, errCount} + (CNTW+1)'(evSum);
    cntNext      = (cntSum > {1'b0, CNT_MAX}) ? CNT_MAX : cntSum[CNTW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clearErr) begin
      orderErr    <= 1'b0;
      unexpErr    <= 1'b0;
      overflowErr <= 1'b0;
      hazardErr   <= 1'b0;
      errCount    <= '0;
    end else begin
      orderErr    <= orderErr    | evOrder;
      unexpErr    <= unexpErr    | evUnexp;
      overflowErr <= overflowErr | evOver;
      hazardErr   <= hazardErr   | evHaz;
      errCount    <= cntNext;
    end
  end

  // R8: flags hold without a clear.
  a_r8_sticky_order: assert property (@(posedge clk) disable iff (!rst_n)
    orderErr && !clearErr |=> orderErr);
  a_r8_sticky_hazard: assert property (@(posedge clk) disable iff (!rst_n)
    hazardErr && !clearErr |=> hazardErr);

  // R8: a clear wins over same-cycle events.
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clearErr |=> (errCount == '0) && !orderErr && !unexpErr && !overflowErr && !hazardErr);

  // R9: the counter holds at its ceiling and never steps down without a clear.
  a_r9_saturate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (errCount == CNT_MAX) && !clearErr |=> errCount == CNT_MAX);
  a_r9_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
    !clearErr |=> errCount >= $past(errCount));

  // R6: an overflow flag only rises after a request met a full table.
  a_r6_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflowErr) |-> $past(reqFire && stat.full));

endmodule

// File: rtl/txn_order_monitor.sv
module txn_order_monitor
  import txn_order_pkg::*;
#(
  parameter int IS_READ = 1,
  parameter int DEPTH   = 8,
  parameter int IDW     = 4,
  parameter int TAGW    = 4,
  parameter int AW      = 32,
  parameter int LENW    = 8,
  parameter int SIZEW   = 3,
  parameter int CNTW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clearErr,
  input  logic             reqValid,
  input  logic             reqReady,
  input  logic [IDW-1:0]   reqId,
  input  logic [AW-1:0]    reqAddr,
  input  logic [LENW-1:0]  reqLen,
  input  logic [SIZEW-1:0] reqSize,
  input  logic [TAGW-1:0]  reqTag,
  input  logic             rspValid,
  input  logic             rspReady,
  input  logic [IDW-1:0]   rspId,
  input  logic [TAGW-1:0]  rspTag,
  input  logic             rspLast,
  output logic             orderErr,
  output logic             unexpErr,
  output logic             overflowErr,
  output logic             hazardErr,
  output logic [CNTW-1:0]  errCount
);
  // Sequence numbers cover every slot of one ID plus one wrap bit.
  localparam int   SEQW        = $clog2(DEPTH) + 1;
  localparam logic IGNORE_LAST = (IS_READ == 0);

  tblStrobe_t strb;
  tblStatus_t stat;
  logic reqFire, rspFire;

  assign reqFire = reqValid && reqReady;
  assign rspFire = rspValid && rspReady && (rspLast || IGNORE_LAST);

  txn_order_table #(
    .DEPTH(DEPTH), .IDW(IDW), .TAGW(TAGW), .AW(AW),
    .LENW(LENW), .SIZEW(SIZEW), .SEQW(SEQW)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .reqId(reqId), .reqAddr(reqAddr), .reqLen(reqLen), .reqSize(reqSize), .reqTag(reqTag),
    .rspId(rspId), .rspTag(rspTag), .stat(stat)
  );

  txn_order_ctrl #(.CNTW(CNTW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clearErr(clearErr),
    .reqFire(reqFire), .rspFire(rspFire), .stat(stat), .strb(strb),
    .orderErr(orderErr), .unexpErr(unexpErr), .overflowErr(overflowErr),
    .hazardErr(hazardErr), .errCount(errCount)
  );

  // R2: in read mode a non-last beat never retires an entry.
  a_r2_nonlast_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_READ != 0) && !rspLast |-> !strb.retire);

endmodule

// File: tb/txn_order_monitor_bench.sv
module txn_order_monitor_bench;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0, clearErr = 1'b0;
  logic reqValid = 1'b0, reqReady = 1'b0, rspValid = 1'b0, rspReady = 1'b0, rspLast = 1'b0;
  logic [3:0]  reqId = '0, reqTag = '0, rspId = '0, rspTag = '0;
  logic [31:0] reqAddr = '0;
  logic [7:0]  reqLen = '0;
  logic [2:0]  reqSize = '0;
  logic orderErr, unexpErr, overflowErr, hazardErr;
  logic [7:0] errCount;

  always #4 clk = ~clk;   // 125 MHz

  txn_order_monitor u_txn_order_monitor (
    .clk(clk), .rst_n(rst_n), .clearErr(clearErr),
    .reqValid(reqValid), .reqReady(reqReady), .reqId(reqId), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqSize(reqSize), .reqTag(reqTag),
    .rspValid(rspValid), .rspReady(rspReady), .rspId(rspId), .rspTag(rspTag), .rspLast(rspLast),
    .orderErr(orderErr), .unexpErr(unexpErr), .overflowErr(overflowErr),
    .hazardErr(hazardErr), .errCount(errCount)
  );

  // Reference table built from the requirements.
  bit        mValid[DEPTH];
  bit [3:0]  mId[DEPTH], mTag[DEPTH], mSeq[DEPTH];
  bit [32:0] mStart[DEPTH], mEnd[DEPTH];
  bit [3:0]  mIssue[16], mRetire[16];
  bit eOrd, eUnx, eOvf, eHaz;
  int eCnt;
  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic modelReset();
    for (int i = 0; i < DEPTH; i++) mValid[i] = 0;
    for (int j = 0; j < 16; j++) begin mIssue[j] = 0; mRetire[j] = 0; end
    eOrd = 0; eUnx = 0; eOvf = 0; eHaz = 0; eCnt = 0;
  endtask

  task automatic modelStep();
    bit evO = 0, evU = 0, evV = 0, evH = 0, full = 1;
    int k = -1, f = -1;
    bit [32:0] s, e;
    if (rspValid && rspReady && rspLast) begin
      for (int i = DEPTH - 1; i >= 0; i--)
        if (mValid[i] && mId[i] == rspId && mTag[i] == rspTag) k = i;
      if (k < 0) evU = 1;
      else if (mSeq[k] != mRetire[rspId]) evO = 1;
    end
    if (reqValid && reqReady) begin
      for (int i = 0; i < DEPTH; i++) full &= mValid[i];
      for (int i = DEPTH - 1; i >= 0; i--) if (!mValid[i]) f = i;
      s = {1'b0, reqAddr};
      e = s + ((33'(reqLen) + 33'd1) << reqSize) - 33'd1;
      if (full) evV = 1;
      else
        for (int i = 0; i < DEPTH; i++)
          if (mValid[i] && mId[i] != reqId && mStart[i] <= e && s <= mEnd[i]) evH = 1;
      if (!full) begin
        mValid[f] = 1; mId[f] = reqId; mTag[f] = reqTag; mStart[f] = s; mEnd[f] = e;
        mSeq[f] = mIssue[reqId]; mIssue[reqId] = mIssue[reqId] + 4'd1;
      end
    end
    if (k >= 0) begin mValid[k] = 0; mRetire[rspId] = mRetire[rspId] + 4'd1; end
    if (clearErr) begin
      eOrd = 0; eUnx = 0; eOvf = 0; eHaz = 0; eCnt = 0;
    end else begin
      eOrd |= evO; eUnx |= evU; eOvf |= evV; eHaz |= evH;
      eCnt = eCnt + int'(evO) + int'(evU) + int'(evV) + int'(evH);
      if (eCnt > 255) eCnt = 255;
    end
  endtask

  task automatic compareAll(string tg);
    checks++;
    if (orderErr !== eOrd || unexpErr !== eUnx || overflowErr !== eOvf ||
        hazardErr !== eHaz || errCount !== 8'(eCnt)) begin
      errors++;
      $display("FAIL %s: got ord=%0b unx=%0b ovf=%0b haz=%0b cnt=%0d, expected ord=%0b unx=%0b ovf=%0b haz=%0b cnt=%0d",
               tg, orderErr, unexpErr, overflowErr, hazardErr, errCount, eOrd, eUnx, eOvf, eHaz, eCnt);
    end
  endtask

  task automatic expectVal(string tg, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d, expected %0d", tg, got, exp);
    end
  endtask

  // Inputs change after a falling edge; results are read one rising edge later.
  task automatic step(string tg);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll(tg);
  endtask

  task automatic idleInputs();
    reqValid = 0; reqReady = 0; rspValid = 0; rspReady = 0; rspLast = 0; clearErr = 0;
  endtask

  task automatic sendReq(input logic [3:0] id, input logic [31:0] addr, input logic [7:0] len,
                         input logic [2:0] size, input logic [3:0] tag, input string tg);
    idleInputs();
    reqValid = 1; reqReady = 1; reqId = id; reqAddr = addr; reqLen = len; reqSize = size; reqTag = tag;
    step(tg);
    idleInputs();
  endtask

  task automatic sendRsp(input logic [3:0] id, input logic [3:0] tag, input logic last, input string tg);
    idleInputs();
    rspValid = 1; rspReady = 1; rspId = id; rspTag = tag; rspLast = last;
    step(tg);
    idleInputs();
  endtask

  task automatic pulseClear(input string tg);
    idleInputs();
    clearErr = 1;
    step(tg);
    idleInputs();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
  end

  initial begin
    int tagCtr = 0;
    void'($urandom(32'd20240611));
    modelReset();
    idleInputs();
    repeat (3) @(negedge clk);
    // R10: reset state, both held in reset and just after release
    expectVal("R10 count in reset", int'(errCount), 0);
    expectVal("R10 flags in reset", int'({orderErr, unexpErr, overflowErr, hazardErr}), 0);
    rst_n = 1;
    step("R10 idle after reset");

    // R1/R2/R11: record, non-last beat, last beat, repeat response
    sendReq(4'd1, 32'h1000, 8'd0, 3'd2, 4'd1, "R1 record");
    sendRsp(4'd1, 4'd1, 1'b0, "R2 non-last beat ignored");
    expectVal("R2 no flag on non-last", int'(unexpErr), 0);
    sendRsp(4'd1, 4'd1, 1'b1, "R1 retire on last");
    expectVal("R11 clean retire", int'(errCount), 0);
    sendRsp(4'd1, 4'd1, 1'b1, "R1 retired entry gone");
    expectVal("R5 unexpected after retire", int'(unexpErr), 1);
    expectVal("R9 count one", int'(errCount), 1);
    // R8: flag holds through idle cycles
    step("R8 sticky idle");
    expectVal("R8 unexpected still set", int'(unexpErr), 1);
    pulseClear("R8 clear");
    expectVal("R8 cleared count", int'(errCount), 0);

    // R3: different IDs return out of order
    sendReq(4'd2, 32'h2000, 8'd1, 3'd2, 4'd2, "R3 req a");
    sendReq(4'd3, 32'h3000, 8'd1, 3'd2, 4'd3, "R3 req b");
    sendRsp(4'd3, 4'd3, 1'b1, "R3 rsp b first");
    sendRsp(4'd2, 4'd2, 1'b1, "R3 rsp a second");
    expectVal("R3 no ordering fault", int'(orderErr), 0);

    // R4: same ID swapped (also R7: same-ID overlap raises no hazard)
    sendReq(4'd5, 32'h4000, 8'd3, 3'd2, 4'd4, "R4 req older");
    sendReq(4'd5, 32'h4004, 8'd3, 3'd2, 4'd5, "R7 same id overlap");
    expectVal("R7 same id no hazard", int'(hazardErr), 0);
    sendRsp(4'd5, 4'd5, 1'b1, "R4 younger first");
    expectVal("R4 ordering fault", int'(orderErr), 1);
    sendRsp(4'd5, 4'd4, 1'b1, "R4 older second");
    expectVal("R4 two events", int'(errCount), 2);

    // R8: clear wins over a same-cycle unexpected response
    idleInputs();
    clearErr = 1; rspValid = 1; rspReady = 1; rspId = 4'd9; rspTag = 4'd9; rspLast = 1;
    step("R8 clear wins");
    idleInputs();
    expectVal("R8 clear beats event", int'(unexpErr), 0);

    // R7: adjacent ranges versus overlapping ranges across IDs
    sendReq(4'd1, 32'h100, 8'd3, 3'd2, 4'd6, "R7 base 0x100-0x10f");
    sendReq(4'd2, 32'h110, 8'd0, 3'd2, 4'd7, "R7 adjacent");
    expectVal("R7 adjacent no hazard", int'(hazardErr), 0);
    sendReq(4'd3, 32'h10c, 8'd0, 3'd0, 4'd8, "R7 overlap");
    expectVal("R7 hazard raised", int'(hazardErr), 1);
    sendRsp(4'd1, 4'd6, 1'b1, "R7 drain 1");
    sendRsp(4'd2, 4'd7, 1'b1, "R7 drain 2");
    sendRsp(4'd3, 4'd8, 1'b1, "R7 drain 3");
    pulseClear("R8 clear");

    // R6: fill the table, then one more
    for (int i = 0; i < DEPTH; i++)
      sendReq(4'(8 + i % 2), 32'h8000 + 32'(i) * 32'h100, 8'd0, 3'd0, 4'(i), "R6 fill");
    expectVal("R6 no overflow at depth", int'(overflowErr), 0);
    sendReq(4'd12, 32'hF000, 8'd0, 3'd0, 4'd15, "R6 overflow");
    expectVal("R6 overflow raised", int'(overflowErr), 1);
    sendRsp(4'd12, 4'd15, 1'b1, "R6 dropped request unknown");
    expectVal("R6 dropped gives unexpected", int'(unexpErr), 1);
    for (int i = 0; i < DEPTH; i++)
      sendRsp(4'(8 + i % 2), 4'(i), 1'b1, "R6 drain");
    expectVal("R6 drain in order", int'(orderErr), 0);
    pulseClear("R8 clear");

    // R9: saturation
    for (int i = 0; i < 260; i++) sendRsp(4'd14, 4'd14, 1'b1, "R9 saturate");
    expectVal("R9 ceiling", int'(errCount), 255);
    pulseClear("R8 clear");

    // Seeded random traffic covering R1 R3 R4 R5 R6 R7 R8 R9
    for (int n = 0; n < 4000; n++) begin
      int k;
      reqValid = 1'($urandom % 2);
      reqReady = 1'(($urandom % 4) != 0);
      reqId    = 4'($urandom % 4);
      reqAddr  = 32'($urandom % 256);
      reqLen   = 8'($urandom % 4);
      reqSize  = 3'($urandom % 3);
      reqTag   = 4'(tagCtr);
      if (reqValid && reqReady) tagCtr = (tagCtr + 1) % 16;
      rspValid = 1'($urandom % 2);
      rspReady = 1'(($urandom % 4) != 0);
      rspLast  = 1'(($urandom % 5) != 0);
      k = int'($urandom % DEPTH);
      if (($urandom % 10) < 7 && mValid[k]) begin
        rspId = mId[k]; rspTag = mTag[k];
      end else begin
        rspId = 4'($urandom % 4); rspTag = 4'($urandom % 16);
      end
      clearErr = 1'(($urandom % 200) == 0);
      step("R1 R3 R4 R5 R6 R7 R9 random");
    end
    idleInputs();
    summary();
  end
endmodule